// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block stands in for the digital side of a 14-bit sampling converter's three-wire serial port. A host drives an active-low select line and a data clock. The block takes a two's complement sample from a parallel input and returns it serially on a single data line that can be tri-stated. A separate output shows when the data line is being driven. The block does no analog work. In place of the real power behaviour, it reports one of three power states.

The select and data clock inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer and an edge-detect register. A frame starts when select goes low. The block then counts falling edges of the data clock. The count picks which bit goes onto the line:

- a quiet sampling window,
- a zero lead-in bit,
- the word, highest bit first,
- two zero pad bits,
- a zero and then the same word, lowest bit first,
- a steady zero until select rises.

The host can stop a frame at any point by raising select.

Top module: `adc_serial_port`

## Requirements
- R1: While the synchronized select is high, `sdo_oe` is 0. Raising select in the middle of a frame returns `sdo_oe` to 0. After reset, `sdo_oe` is 0.
- R2: The parallel sample is captured when select falls. Any change to `sample_in` after that point has no effect on the bits sent in that frame.
- R3: For falling data-clock edges 1 to 4 of a frame, `sdo_oe` stays 0. At edge 5, `sdo_oe` goes to 1 and `sdo` is 0.
- R4: Falling edges 6 through 19 put sample bits 13 down to 0 on `sdo`, one bit per edge.
- R5: Falling edges 20 and 21 put a 0 on `sdo`.
- R6: Falling edge 22 puts a 0 on `sdo`. Edges 23 through 36 then put sample bits 0 up to 13 on `sdo`.
- R7: From edge 37 onward, while select stays low, `sdo_oe` is 1 and `sdo` holds 0 no matter how many more clocks arrive.
- R8: Data-clock edges that arrive while select is high do not start a frame. A new frame always begins at edge count zero and uses the newly captured sample.
- R9: `pwr_state` has three codes:
  - 2'b10 while select is high (full shutdown);
  - 2'b00 while select is low and fewer than 20 falling edges have been seen (converting);
  - 2'b01 while select is low from edge 20 onward (analog section idle).
- R10: Output bits change only on falling data-clock edges. A rising edge leaves `sdo`, `sdo_oe` and `pwr_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Host select, active low, asynchronous |
| sclk_in | input | 1 | Host data clock, asynchronous |
| sample_in | input | 14 | Two's complement sample, captured when select falls |
| sdo | output | 1 | Serial data line, high impedance when not enabled |
| sdo_oe | output | 1 | High while the data line is driven |
| pwr_state | output | 2 | 00 converting, 01 analog idle, 10 full shutdown |

## Verification
When `cs_n_in` or `sclk_in` changes, the three registers on the path mean that `sdo`, `sdo_oe` and `pwr_state` take their new values on the third rising system-clock edge afterwards. The bench changes each host input on a falling system-clock edge and holds it for four system clocks. It samples all outputs on the last falling edge of that hold, one cycle after the result is due and before the next input change. A sample taken at the end of each high phase of the data clock shows that rising edges change nothing. The sample input is replaced with its complement one hold period after select falls, so any late capture would change the bits sent.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE   = 2'b00,
    PWR_ANA_IDLE = 2'b01,
    PWR_FULL_OFF = 2'b10
  } pwr_e;

  typedef enum logic [2:0] {
    SLOT_QUIET,
    SLOT_NULL,
    SLOT_MSB,
    SLOT_PAD,
    SLOT_REPZ,
    SLOT_LSB,
    SLOT_HOLD
  } slot_e;

  // Map a 1-based falling-edge count to the part of the frame it belongs to.
  function automatic slot_e classify(input int k, input int null_at,
                                     input int dw, input int pads);
    int msb_hi;
    int repz;
    int lsb_hi;
    msb_hi = null_at + dw;
    repz   = msb_hi + pads + 1;
    lsb_hi = repz + dw;
    if (k < null_at)       return SLOT_QUIET;
    else if (k == null_at) return SLOT_NULL;
    else if (k <= msb_hi)  return SLOT_MSB;
    else if (k < repz)     return SLOT_PAD;
    else if (k == repz)    return SLOT_REPZ;
    else if (k <= lsb_hi)  return SLOT_LSB;
    else                   return SLOT_HOLD;
  endfunction

endpackage

// File: rtl/adcser_sync.sv
module adcser_sync #(
  parameter int unsigned W = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] prev
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < DEPTH; s++) chain[s] <= chain[s-1];
    end
  end

  assign level = chain[STAGES-1];
  assign prev  = chain[STAGES];

endmodule

// File: rtl/adcser_framer.sv
module adcser_framer #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned NULL_AT = 5,
  parameter int unsigned PADS = 2,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_hi,
  input  logic             sclk_fall,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             step
);
  // Saturation point: one past the last lowest-bit-first slot.
  localparam int unsigned SAT = NULL_AT + DATA_W + PADS + 1 + DATA_W + 1;

  always_comb begin
    cnt_d = cnt_q;
    step  = 1'b0;
    if (cs_hi) begin
      cnt_d = '0;
    end else if (sclk_fall) begin
      step = 1'b1;
      if (cnt_q != CNT_W'(SAT)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R7: the edge count never passes the hold slot.
  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(SAT));

  // R10: without a falling data-clock edge the count cannot move while selected.
  assert_cnt_only_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !cs_hi) |=> $stable(cnt_q));

  // R8: high select always clears the count for the next frame.
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (cnt_q == '0));

endmodule

// File: rtl/adcser_word.sv
module adcser_word
  import adcser_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned NULL_AT = 5,
  parameter int unsigned PADS = 2,
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [CNT_W-1:0]  cnt_d,
  output logic              drive_d,
  output logic              bit_d
);
  localparam int unsigned IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int          MSB_HI = int'(NULL_AT + DATA_W);
  localparam int          REPZ   = int'(NULL_AT + DATA_W + PADS + 1);

  logic [DATA_W-1:0] word_q;
  slot_e             slot;
  int                idx;
  logic [IDX_W-1:0]  sel;

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= sample_in;
  end

  always_comb begin
    slot = classify(int'(cnt_d), int'(NULL_AT), int'(DATA_W), int'(PADS));
    idx  = 0;
    if (slot == SLOT_MSB)      idx = MSB_HI - int'(cnt_d);
    else if (slot == SLOT_LSB) idx = int'(cnt_d) - REPZ - 1;
    sel     = IDX_W'(idx);
    drive_d = (slot != SLOT_QUIET);
    bit_d   = ((slot == SLOT_MSB) || (slot == SLOT_LSB)) ? word_q[sel] : 1'b0;
  end

  // R2: the captured word only changes on a select falling edge.
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_q));

  // R5: slots that are not data slots never carry a one.
  assert_zero_slots_R5: assert property (@(posedge clk) disable iff (rst)
    ((slot == SLOT_PAD) || (slot == SLOT_NULL) || (slot == SLOT_REPZ) ||
     (slot == SLOT_HOLD)) |-> !bit_d);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adcser_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned NULL_AT = 5,
  parameter int unsigned PADS = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_in,
  input  logic              sclk_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [1:0]        pwr_state
);
  localparam int unsigned SAT     = NULL_AT + DATA_W + PADS + 1 + DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(SAT + 1);
  localparam int unsigned IDLE_AT = NULL_AT + DATA_W + 1;
  localparam int unsigned I_CS    = 0;
  localparam int unsigned I_SCK   = 1;

  logic [1:0]       lvl, prv;
  logic             cs_hi, cs_fall, sclk_fall;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, drive_d, bit_d;
  logic             oe_q, val_q;
  pwr_e             pwr_q;

  adcser_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .din({sclk_in, cs_n_in}), .level(lvl), .prev(prv)
  );

  assign cs_hi     = lvl[I_CS];
  assign cs_fall   = prv[I_CS] & ~lvl[I_CS];
  assign sclk_fall = prv[I_SCK] & ~lvl[I_SCK];

  adcser_framer #(.DATA_W(DATA_W), .NULL_AT(NULL_AT), .PADS(PADS), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .sclk_fall(sclk_fall),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .step(step)
  );

  adcser_word #(.DATA_W(DATA_W), .NULL_AT(NULL_AT), .PADS(PADS), .CNT_W(CNT_W)) u_word (
    .clk(clk), .rst(rst), .load(cs_fall), .sample_in(sample_in),
    .cnt_d(cnt_d), .drive_d(drive_d), .bit_d(bit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      val_q <= 1'b0;
      pwr_q <= PWR_FULL_OFF;
    end else if (cs_hi) begin
      oe_q  <= 1'b0;
      val_q <= 1'b0;
      pwr_q <= PWR_FULL_OFF;
    end else begin
      if (step) begin
        oe_q  <= drive_d;
        val_q <= bit_d;
      end
      pwr_q <= (cnt_d >= CNT_W'(IDLE_AT)) ? PWR_ANA_IDLE : PWR_ACTIVE;
    end
  end

  assign sdo       = oe_q ? val_q : 1'bz;
  assign sdo_oe    = oe_q;
  assign pwr_state = pwr_q;

  // R3: when the driver turns on, the first bit is the zero lead-in.
  assert_null_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !val_q);

  // R1: the driver only turns off when select is high (full shutdown).
  assert_release_on_cs_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_q) |-> (pwr_q == PWR_FULL_OFF));

  // R9: a driven line never coexists with full shutdown.
  assert_drive_not_off_R9: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (pwr_q != PWR_FULL_OFF));

  // R9: analog idle is reached only after the driver is on.
  assert_idle_driven_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_q == PWR_ANA_IDLE) |-> oe_q);

endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 14;
  localparam int PH = 4;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b0;
  logic [DW-1:0] sample = '0;
  wire           sdo;
  wire           sdo_oe;
  wire  [1:0]    pwr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port uut (
    .clk(clk), .rst(rst), .cs_n_in(cs_n), .sclk_in(sclk),
    .sample_in(sample), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_state(pwr)
  );

  // {oe, data} expected after k falling edges of a frame carrying word w.
  function automatic logic [1:0] exp_line(int k, logic [DW-1:0] w);
    if (k < 5)        return 2'b00;
    else if (k == 5)  return 2'b10;
    else if (k <= 19) return {1'b1, w[19-k]};
    else if (k <= 22) return 2'b10;
    else if (k <= 36) return {1'b1, w[k-23]};
    else              return 2'b10;
  endfunction

  function automatic logic [1:0] exp_pwr(int k);
    return (k >= 20) ? 2'b01 : 2'b00;
  endfunction

  function automatic string tag_of(int k);
    if (k < 5)        return "R3 quiet";
    else if (k == 5)  return "R3 null";
    else if (k <= 19) return "R4 R2 msb-first";
    else if (k <= 21) return "R5 pad";
    else if (k <= 36) return "R6 lsb-first";
    else              return "R7 hold";
  endfunction

  function automatic logic [1:0] line_now();
    return {sdo_oe, sdo_oe ? sdo : 1'b0};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_in_frame(int k, logic [DW-1:0] w);
    sclk = 1'b1;
    tick(PH);
    chk("R10 rising edge", {14'd0, line_now()}, {14'd0, exp_line(k-1, w)});
    sclk = 1'b0;
    tick(PH);
    chk(tag_of(k), {14'd0, line_now()}, {14'd0, exp_line(k, w)});
    chk("R9 power", {14'd0, pwr}, {14'd0, exp_pwr(k)});
  endtask

  task automatic run_frame(logic [DW-1:0] w, int nf);
    sample = w;
    cs_n = 1'b0;
    tick(PH);
    sample = ~w;
    chk("R3 before edges", {15'd0, sdo_oe}, 16'd0);
    chk("R9 converting", {14'd0, pwr}, 16'd0);
    for (int k = 1; k <= nf; k++) pulse_in_frame(k, w);
    cs_n = 1'b1;
    tick(PH);
    chk("R1 release", {15'd0, sdo_oe}, 16'd0);
    chk("R9 shutdown", {14'd0, pwr}, 16'h2);
  endtask

  task automatic idle_clocks(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      tick(PH);
      sclk = 1'b0;
      tick(PH);
      chk("R8 clocks while deselected", {13'd0, sdo_oe, pwr}, 16'h2);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    rst = 1'b0;
    tick(PH);
    chk("R1 reset oe", {15'd0, sdo_oe}, 16'd0);
    chk("R9 reset power", {14'd0, pwr}, 16'h2);

    run_frame(14'h1FFF, 40);
    run_frame(14'h2000, 37);
    run_frame(14'h0000, 22);
    run_frame(14'h3FFF, 12);
    idle_clocks(3);
    run_frame(14'h2AAA, 45);
    run_frame(14'h1555, 5);
    idle_clocks(2);
    run_frame(14'h0001, 20);
    for (int f = 0; f < 20; f++) begin
      logic [DW-1:0] w;
      int nf;
      w  = DW'($urandom);
      nf = int'($urandom_range(0, 44));
      run_frame(w, nf);
      if ((f % 5) == 0) idle_clocks(1);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule